// File: doc/BRIEF.md
# Planar Pixel Plotter with Dither and Palette Nibble

This block turns single-cycle pixel plot commands into byte writes to a frame buffer that is laid out as 8x8 bit-planar tiles. The drawing engine keeps two coordinate registers, `x` and `y`. Software loads them once. Each accepted plot then writes the current colour at that position and steps `x` by one, so the caller never computes a frame-buffer address.

The colour comes from an 8-bit colour register and three mode inputs:
- A checkerboard dither mode picks one of two nibbles from the parity of x+y.
- In 8-bpp mode a palette mode places a 4-bit colour under a fixed upper nibble.

Plotted pixels are collected in a one-row cache that holds eight horizontally adjacent pixels. A separate write-back engine empties the cache one bitplane byte at a time. It reads and merges the old byte whenever the row is only partly filled. The plot command therefore completes in one cycle. It is held off only when it needs a write-back while the previous one is still in progress.

Top module: `pixel_plot`

## Requirements
- R1: Pixel (x,y) lives in tile t = (y/8)*TILES_W + x/8. Bitplane p of that pixel is the byte at t*B + (y%8)*2 + (p/2)*16 + (p%2). B is 32 with four planes (4-bpp) or 64 with eight planes (8-bpp). The pixel with x%8 = 0 is bit 7 of each byte, and x%8 = 7 is bit 0.
- R2: Each accepted plot increments `x` by one modulo the screen width of TILES_W*8 and leaves `y` unchanged. `load_i` sets both coordinates.
- R3: A plot presented while `stall_o` is low is accepted at that clock edge.
- R4: In 4-bpp mode the pixel is `color_i[3:0]`. With dither on, the pixel is `color_i[7:4]` when x+y is odd and `color_i[3:0]` when x+y is even.
- R5: In 8-bpp mode without palette mode the pixel is `color_i` and dither has no effect.
- R6: In 8-bpp palette mode the pixel is {`pal_hi_i`, nibble}, where the nibble is chosen as in R4.
- R7: When the eighth pixel of a cached row is plotted, the row is written with one write per bitplane and no reads.
- R8: A partly filled row is written back by reading each plane byte and writing it back next cycle to the same address. Pixels that were not plotted keep their earlier value.
- R9: `stall_o` is high while a plot or flush needs a write-back and the engine is busy. While stalled, the coordinates do not change.
- R10: `flush_i` (with `plot_i` low) writes back a non-empty cache. With an empty cache it causes no memory access.
- R11: After reset `stall_o`, `mem_re_o` and `mem_we_o` are low and both coordinates are zero.
- R12: A read and a write are never issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Load both coordinate registers |
| load_x_i | input | XW | New x coordinate |
| load_y_i | input | YW | New y coordinate |
| plot_i | input | 1 | Plot command |
| flush_i | input | 1 | Write back the cached row |
| color_i | input | 8 | Colour register |
| pal_hi_i | input | 4 | Fixed upper nibble for palette mode |
| dither_i | input | 1 | Checkerboard dither enable |
| bpp8_i | input | 1 | 1 = 8-bpp tiles, 0 = 4-bpp tiles |
| pal4_i | input | 1 | 8-bpp palette mode |
| stall_o | output | 1 | Command held off |
| x_o | output | XW | Current x coordinate |
| y_o | output | YW | Current y coordinate |
| mem_re_o | output | 1 | Frame-buffer read request (data one cycle later) |
| mem_we_o | output | 1 | Frame-buffer byte write |
| mem_addr_o | output | AW | Frame-buffer byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data for the previous cycle's read |

## Verification
A wrong cache tag or fill mask shows up at the memory port. A row is then written with reads when it should have none, or without the merge it needs, or a pixel next to the plotted one is cleared. All of this is visible within a few cycles of the next flush. A corrupted plane counter or address term lands the bits in the wrong byte, which a read-back of the plotted pixel reveals. A wrong coordinate step or stall condition shows at `x_o` and `stall_o` in the very next cycle.

// File: rtl/pp_pkg.sv
package pp_pkg;
   typedef logic [7:0] pix_t;

   typedef struct packed {
      logic [7:0][7:0] pix;   // pixel i at index i (i = x % 8)
      logic [7:0]      mask;  // bit (7-i) set when pixel i was plotted
      logic            bpp8;  // row layout: 1 = eight planes
   } row_t;
endpackage

// File: rtl/pp_color.sv
module pp_color (
   input  logic [7:0] color_i,
   input  logic [3:0] pal_hi_i,
   input  logic       odd_i,
   input  logic       dither_i,
   input  logic       bpp8_i,
   input  logic       pal4_i,
   output pp_pkg::pix_t pix_o
);
   logic [3:0] nib;

   assign nib = (dither_i && odd_i) ? color_i[7:4] : color_i[3:0];

   always_comb begin
      if (bpp8_i && !pal4_i)   pix_o = color_i;
      else if (bpp8_i)         pix_o = {pal_hi_i, nib};
      else                     pix_o = {4'h0, nib};
   end
endmodule

// File: rtl/pp_wb.sv
module pp_wb #(
   parameter int TILES_W = 32,
   parameter int TXW     = 5,
   parameter int YW      = 8,
   parameter int AW      = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  pp_pkg::row_t       row_i,
   input  logic [TXW-1:0]     tx_i,
   input  logic [YW-1:0]      ty_i,
   output logic               busy_o,
   output logic               mem_re_o,
   output logic               mem_we_o,
   output logic [AW-1:0]      mem_addr_o,
   output logic [7:0]         mem_wdata_o,
   input  logic [7:0]         mem_rdata_i
);
   pp_pkg::row_t   row_q;
   logic [TXW-1:0] tx_q;
   logic [YW-1:0]  ty_q;
   logic           busy_q, rd_ph_q;
   logic [2:0]     plane_q;
   logic           partial, last;
   logic [7:0]     newb, merged;
   logic [AW-1:0]  tile, tbase;

   assign partial = (row_q.mask != 8'hFF);
   assign last    = (plane_q == (row_q.bpp8 ? 3'd7 : 3'd3));

   for (genvar i = 0; i < 8; i++) begin : g_bit
      assign newb[7-i] = row_q.pix[i][plane_q];
   end

   assign merged = (newb & row_q.mask) | (mem_rdata_i & ~row_q.mask);

   assign tile  = AW'(ty_q[YW-1:3]) * AW'(TILES_W) + AW'(tx_q);
   assign tbase = row_q.bpp8 ? (tile << 6) : (tile << 5);

   assign mem_addr_o  = tbase + AW'({ty_q[2:0], 1'b0})
                      + AW'({plane_q[2:1], 4'b0000}) + AW'(plane_q[0]);
   assign mem_re_o    = busy_q && rd_ph_q;
   assign mem_we_o    = busy_q && !rd_ph_q;
   assign mem_wdata_o = partial ? merged : newb;
   assign busy_o      = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         rd_ph_q <= 1'b0;
         plane_q <= '0;
         row_q   <= '0;
         tx_q    <= '0;
         ty_q    <= '0;
      end else if (!busy_q) begin
         if (start_i) begin
            busy_q  <= 1'b1;
            row_q   <= row_i;
            tx_q    <= tx_i;
            ty_q    <= ty_i;
            plane_q <= '0;
            rd_ph_q <= (row_i.mask != 8'hFF);
         end
      end else if (rd_ph_q) begin
         rd_ph_q <= 1'b0;
      end else begin
         if (last) busy_q <= 1'b0;
         else      plane_q <= plane_q + 3'd1;
         rd_ph_q <= partial;
      end
   end
endmodule

// File: rtl/pixel_plot.sv
module pixel_plot #(
   parameter int TILES_W = 32,
   parameter int TILES_H = 24,
   parameter int AW      = 16,
   localparam int XW     = $clog2(TILES_W * 8),
   localparam int YW     = $clog2(TILES_H * 8),
   localparam int TXW    = XW - 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [XW-1:0] load_x_i,
   input  logic [YW-1:0] load_y_i,
   input  logic          plot_i,
   input  logic          flush_i,
   input  logic [7:0]    color_i,
   input  logic [3:0]    pal_hi_i,
   input  logic          dither_i,
   input  logic          bpp8_i,
   input  logic          pal4_i,
   output logic          stall_o,
   output logic [XW-1:0] x_o,
   output logic [YW-1:0] y_o,
   output logic          mem_re_o,
   output logic          mem_we_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [7:0]    mem_wdata_o,
   input  logic [7:0]    mem_rdata_i
);
   if (TILES_W < 2 || (TILES_W & (TILES_W - 1)) != 0) begin : g_bad_w
      $error("TILES_W must be a power of two of at least 2");
   end
   if (TILES_H < 2) begin : g_bad_h
      $error("TILES_H must be at least 2");
   end
   if ((64'(1) << AW) < 64'(TILES_W * TILES_H * 64)) begin : g_bad_aw
      $error("AW too narrow for the frame buffer");
   end

   logic [XW-1:0]   x_q;
   logic [YW-1:0]   y_q;
   logic [7:0]      mask_q;
   logic [7:0][7:0] pix_q, pix_ins;
   logic [TXW-1:0]  tagx_q;
   logic [YW-1:0]   tagy_q;
   logic            tbpp_q;

   pp_pkg::pix_t new_pix;
   pp_pkg::row_t snap;
   logic [2:0] slot;
   logic [7:0] bitm;
   logic tag_eq, empty, miss, fill, plot_flush, cmd_flush, need, take, accept;
   logic wb_busy;

   pp_color u_color (
      .color_i (color_i), .pal_hi_i (pal_hi_i), .odd_i (x_q[0] ^ y_q[0]),
      .dither_i (dither_i), .bpp8_i (bpp8_i), .pal4_i (pal4_i), .pix_o (new_pix)
   );

   assign slot   = x_q[2:0];
   assign bitm   = 8'h80 >> slot;
   assign tag_eq = (tagx_q == x_q[XW-1:3]) && (tagy_q == y_q) && (tbpp_q == bpp8_i);
   assign empty  = (mask_q == 8'h00);
   assign miss   = !empty && !tag_eq;
   assign fill   = !miss && ((mask_q | bitm) == 8'hFF);

   assign plot_flush = plot_i && (miss || fill);
   assign cmd_flush  = flush_i && !plot_i && !empty;
   assign need       = plot_flush || cmd_flush;
   assign stall_o    = need && wb_busy;
   assign take       = need && !wb_busy;
   assign accept     = plot_i && !stall_o;

   always_comb begin
      pix_ins       = pix_q;
      pix_ins[slot] = new_pix;
      if (miss || cmd_flush) snap = '{pix: pix_q,   mask: mask_q,        bpp8: tbpp_q};
      else                   snap = '{pix: pix_ins, mask: mask_q | bitm, bpp8: tbpp_q};
   end

   pp_wb #(.TILES_W(TILES_W), .TXW(TXW), .YW(YW), .AW(AW)) u_wb (
      .clk (clk), .rst_n (rst_n), .start_i (take), .row_i (snap),
      .tx_i (tagx_q), .ty_i (tagy_q), .busy_o (wb_busy),
      .mem_re_o (mem_re_o), .mem_we_o (mem_we_o), .mem_addr_o (mem_addr_o),
      .mem_wdata_o (mem_wdata_o), .mem_rdata_i (mem_rdata_i)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q    <= '0;
         y_q    <= '0;
         mask_q <= '0;
         pix_q  <= '0;
         tagx_q <= '0;
         tagy_q <= '0;
         tbpp_q <= 1'b0;
      end else begin
         if (load_i) begin
            x_q <= load_x_i;
            y_q <= load_y_i;
         end else if (accept) begin
            x_q <= x_q + 1'b1;
         end
         if (accept) begin
            if (miss)      mask_q <= bitm;
            else if (fill) mask_q <= 8'h00;
            else           mask_q <= mask_q | bitm;
            pix_q  <= pix_ins;
            tagx_q <= x_q[XW-1:3];
            tagy_q <= y_q;
            tbpp_q <= bpp8_i;
         end else if (take) begin
            mask_q <= 8'h00;
         end
      end
   end

   assign x_o = x_q;
   assign y_o = y_q;
endmodule

// File: rtl/pixel_plot_chk.sv
module pixel_plot_chk #(
   parameter int XW = 8,
   parameter int YW = 8,
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          plot_i,
   input logic          load_i,
   input logic          stall_o,
   input logic [XW-1:0] x_o,
   input logic [YW-1:0] y_o,
   input logic          wb_busy,
   input logic          mem_re_o,
   input logic          mem_we_o,
   input logic [AW-1:0] mem_addr_o
);
   AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_re_o && mem_we_o));                                      // R12
   AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re_o |=> mem_we_o && (mem_addr_o == $past(mem_addr_o)));   // R8
   AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (plot_i && !stall_o && !load_i) |=> (x_o == XW'($past(x_o) + 1'b1)) && (y_o == $past(y_o))); // R2
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_o && !load_i) |=> (x_o == $past(x_o)) && (y_o == $past(y_o))); // R9
   AST_STALL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      stall_o |-> wb_busy);                                          // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !wb_busy |-> (!mem_we_o && !mem_re_o));                        // R10
endmodule

bind pixel_plot pixel_plot_chk #(.XW(XW), .YW(YW), .AW(AW)) u_chk (
   .clk (clk), .rst_n (rst_n), .plot_i (plot_i), .load_i (load_i),
   .stall_o (stall_o), .x_o (x_o), .y_o (y_o), .wb_busy (wb_busy),
   .mem_re_o (mem_re_o), .mem_we_o (mem_we_o), .mem_addr_o (mem_addr_o)
);

// File: tb/pixel_plot_test.sv
module pixel_plot_test;
   localparam int PERIOD = 10;
   localparam int TW = 4;
   localparam int TH = 2;
   localparam int XW = 5;
   localparam int YW = 4;

   typedef struct packed {
      logic [7:0] x, y, c;
      logic d, b, p;
      logic [7:0] e;
   } vec_t;

   localparam vec_t VEC [8] = '{
      '{x: 8'd3,  y: 8'd2,  c: 8'h5A, d: 1'b0, b: 1'b0, p: 1'b0, e: 8'h0A},
      '{x: 8'd4,  y: 8'd3,  c: 8'h5A, d: 1'b1, b: 1'b0, p: 1'b0, e: 8'h05},
      '{x: 8'd6,  y: 8'd2,  c: 8'h5A, d: 1'b1, b: 1'b0, p: 1'b0, e: 8'h0A},
      '{x: 8'd9,  y: 8'd5,  c: 8'hC3, d: 1'b0, b: 1'b1, p: 1'b0, e: 8'hC3},
      '{x: 8'd17, y: 8'd12, c: 8'hC3, d: 1'b0, b: 1'b1, p: 1'b1, e: 8'h73},
      '{x: 8'd30, y: 8'd15, c: 8'h3E, d: 1'b1, b: 1'b1, p: 1'b1, e: 8'h73},
      '{x: 8'd31, y: 8'd0,  c: 8'h96, d: 1'b1, b: 1'b1, p: 1'b0, e: 8'h96},
      '{x: 8'd0,  y: 8'd7,  c: 8'h0F, d: 1'b1, b: 1'b0, p: 1'b0, e: 8'h00}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic load_i = 1'b0, plot_i = 1'b0, flush_i = 1'b0;
   logic [XW-1:0] load_x_i = '0;
   logic [YW-1:0] load_y_i = '0;
   logic [7:0] color_i = '0;
   logic [3:0] pal_hi_i = 4'h7;
   logic dither_i = 1'b0, bpp8_i = 1'b0, pal4_i = 1'b0;
   logic stall_o, mem_re_o, mem_we_o;
   logic [XW-1:0] x_o;
   logic [YW-1:0] y_o;
   logic [15:0] mem_addr_o;
   logic [7:0] mem_wdata_o, mem_rdata_i;

   logic [7:0] mem [0:1023];
   int n_cmp = 0, n_bad = 0, rd_cnt = 0, wr_cnt = 0;

   pixel_plot #(.TILES_W(TW), .TILES_H(TH), .AW(16)) uut (
      .clk (clk), .rst_n (rst_n), .load_i (load_i), .load_x_i (load_x_i),
      .load_y_i (load_y_i), .plot_i (plot_i), .flush_i (flush_i),
      .color_i (color_i), .pal_hi_i (pal_hi_i), .dither_i (dither_i),
      .bpp8_i (bpp8_i), .pal4_i (pal4_i), .stall_o (stall_o), .x_o (x_o),
      .y_o (y_o), .mem_re_o (mem_re_o), .mem_we_o (mem_we_o),
      .mem_addr_o (mem_addr_o), .mem_wdata_o (mem_wdata_o),
      .mem_rdata_i (mem_rdata_i)
   );

   always #(PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      if (mem_we_o) begin mem[mem_addr_o[9:0]] <= mem_wdata_o; wr_cnt <= wr_cnt + 1; end
      if (mem_re_o) begin mem_rdata_i <= mem[mem_addr_o[9:0]]; rd_cnt <= rd_cnt + 1; end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Reads pixel (x,y) back from the tile layout stated in R1.
   function automatic int getpix(input int x, input int y, input bit b8);
      int tile = (y / 8) * TW + x / 8;
      int base = tile * (b8 ? 64 : 32) + (y % 8) * 2;
      int r = 0;
      for (int p = 0; p < (b8 ? 8 : 4); p++)
         r |= int'(mem[base + (p / 2) * 16 + p % 2][7 - (x % 8)]) << p;
      return r;
   endfunction

   task automatic load(input int x, input int y);
      @(negedge clk); load_i = 1'b1; load_x_i = XW'(x); load_y_i = YW'(y);
      @(posedge clk); #1; load_i = 1'b0;
   endtask

   task automatic plot(input logic [7:0] c);
      @(negedge clk); color_i = c; plot_i = 1'b1; #1;
      while (stall_o) begin @(negedge clk); #1; end
      @(posedge clk); #1; plot_i = 1'b0;
   endtask

   task automatic flush();
      @(negedge clk); flush_i = 1'b1; #1;
      while (stall_o) begin @(negedge clk); #1; end
      @(posedge clk); #1; flush_i = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(PERIOD * 100000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int r0, w0;
      for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
      mem_rdata_i = 8'h00;
      #(PERIOD * 3 + 2);
      // R11: reset state
      chk("R11 stall", int'(stall_o), 0);
      chk("R11 rd/wr", int'(mem_re_o | mem_we_o), 0);
      chk("R11 coords", int'({x_o, y_o}), 0);
      rst_n = 1'b1;
      idle(2);

      // Table of single-pixel plots: R1 R3 R4 R5 R6 R8
      for (int v = 0; v < 8; v++) begin
         dither_i = VEC[v].d; bpp8_i = VEC[v].b; pal4_i = VEC[v].p;
         load(int'(VEC[v].x), int'(VEC[v].y));
         plot(VEC[v].c);
         chk("R2 x step", int'(x_o), (int'(VEC[v].x) + 1) % 32);
         chk("R2 y kept", int'(y_o), int'(VEC[v].y));
         flush();
         idle(20);
         chk("R1 R4 R5 R6 pixel", getpix(VEC[v].x, VEC[v].y, VEC[v].b), int'(VEC[v].e));
      end
      // R8: neighbour in same row survives the later merge
      chk("R8 kept pixel", getpix(3, 2, 1'b0), 8'h0A);

      // R8: partial 4-bpp row -> four reads, four writes
      dither_i = 1'b0; bpp8_i = 1'b0; pal4_i = 1'b0;
      r0 = rd_cnt; w0 = wr_cnt;
      load(12, 4); plot(8'h09); flush(); idle(20);
      chk("R8 reads", rd_cnt - r0, 4);
      chk("R8 writes", wr_cnt - w0, 4);
      chk("R8 pixel", getpix(12, 4, 1'b0), 9);

      // R7: full 8-bpp row -> eight writes, no reads, no flush command
      bpp8_i = 1'b1;
      r0 = rd_cnt; w0 = wr_cnt;
      load(8, 9);
      for (int i = 0; i < 8; i++) plot(8'(i * 33 + 5));
      idle(20);
      chk("R7 reads", rd_cnt - r0, 0);
      chk("R7 writes", wr_cnt - w0, 8);
      for (int i = 0; i < 8; i++) chk("R7 pixel", getpix(8 + i, 9, 1'b1), (i * 33 + 5) & 255);

      // R9: miss while a full-row write-back is busy
      load(16, 6);
      for (int i = 0; i < 8; i++) plot(8'(i + 100));
      load(24, 3);
      plot(8'hE1);
      load(8, 3);
      @(negedge clk); color_i = 8'h4C; plot_i = 1'b1; #1;
      chk("R9 stall high", int'(stall_o), 1);
      chk("R9 x held", int'(x_o), 8);
      @(negedge clk); #1;
      chk("R9 x still held", int'(x_o), 8);
      while (stall_o) begin @(negedge clk); #1; end
      @(posedge clk); #1; plot_i = 1'b0;
      chk("R3 x after accept", int'(x_o), 9);
      flush(); idle(30);
      for (int i = 0; i < 8; i++) chk("R9 row pixel", getpix(16 + i, 6, 1'b1), i + 100);
      chk("R9 evicted pixel", getpix(24, 3, 1'b1), 8'hE1);
      chk("R10 flushed pixel", getpix(8, 3, 1'b1), 8'h4C);

      // R10: flush with empty cache touches nothing
      r0 = rd_cnt; w0 = wr_cnt;
      flush(); idle(10);
      chk("R10 empty flush", (rd_cnt - r0) + (wr_cnt - w0), 0);

      finish_run();
   end
endmodule